// File: doc/BRIEF.md
# Grouped Two-Level Interrupt Expander

This block gathers a large set of peripheral interrupt lines, arranged as fixed-size groups, and presents one request line per group to the processor. Each line has its own pending flag and its own enable bit. Each group has an acknowledge latch that holds off further requests from that group until software releases it. A rising edge on a peripheral line marks it pending. A group raises its request while at least one of its lines is both pending and enabled and its acknowledge latch is clear.

After the processor accepts a group's request, it issues a fetch strobe together with the group number. One cycle later the block returns a vector index that names the winning line. In the same cycle as the fetch, the block retires that line's pending flag and sets the group's acknowledge latch. Software manages enables, pending flags and acknowledge latches through a single-cycle write port with four operations.

Top module: `irqx_expander`

## Requirements
- R1: After reset, every pending flag, enable bit and acknowledge latch is clear, every `grp_req` bit is 0 and `vec_valid` is 0.
- R2: A 0-to-1 transition on a peripheral line, seen between two clock edges, sets that line's pending flag. A line that stays high sets the flag only once.
- R3: `grp_req[g]` is 1 exactly when group g has at least one line that is both pending and enabled, and group g's acknowledge latch is clear.
- R4: A write with `wr_op` = 0 ORs `wr_data[7:0]` into the enable bits of group `wr_group`. A write with `wr_op` = 1 clears the enable bits of that group wherever `wr_data[7:0]` has a 1. Bit i of the data maps to line i of the group.
- R5: A fetch strobe for a group in range sets that group's acknowledge latch. While the latch is set, the group's request stays low.
- R6: A write with `wr_op` = 2 clears the acknowledge latch of every group g whose bit `wr_data[g]` is 1. Writing all ones releases every group. A fetch in the same cycle still sets its own group's latch.
- R7: A fetch strobe with `fetch_group` below 12 raises `vec_valid` in the next cycle, with `vec_idx` = group*8 + line, both zero-based. The line is the lowest-numbered line that was pending and enabled at the fetch. A fetch for group 12 or higher gives `vec_valid` = 0.
- R8: A fetch clears the pending flag of the line it returns.
- R9: If no line of the fetched group is both pending and enabled, the returned vector is group*8 (line 0) and no pending flag changes.
- R10: A write with `wr_op` = 3 clears the pending flags of group `wr_group` wherever `wr_data[7:0]` has a 1.
- R11: If a new rising edge and a clear of the same pending flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Peripheral lines; line l of group g is bit g*8+l |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 enable set, 1 enable clear, 2 acknowledge clear, 3 pending clear |
| wr_group | input | 4 | Target group for enable and pending operations |
| wr_data | input | 12 | Line mask in bits 7:0, or group mask for acknowledge clear |
| fetch_strobe | input | 1 | Processor accepted a group request |
| fetch_group | input | 4 | Zero-based group being accepted |
| grp_req | output | 12 | Per-group request to the processor |
| vec_valid | output | 1 | Vector index valid, one cycle after a fetch |
| vec_idx | output | 7 | Returned vector index, group*8+line |

## Verification
The checker enforces the following on every cycle:
- A group never requests while its acknowledge latch is set.
- Every request is backed by an enabled pending line.
- A fetch always leaves its group acknowledged.
- `vec_valid` follows in-range fetches by exactly one cycle, and the returned vector carries the fetched group number.
- An acknowledge-clear write releases the masked groups.

Some properties need history and choices across many cycles, so only the bench scenarios show them:
- Priority among several pending lines.
- The spurious line-0 vector.
- A held-high line not retriggering.
- Pending flags surviving a disabled fetch.
- Edge-versus-clear collisions.

A behavioural model compares the request lines and vectors with the design on every clock.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  typedef enum logic [1:0] {
    OP_EN_SET  = 2'd0,
    OP_EN_CLR  = 2'd1,
    OP_ACK_CLR = 2'd2,
    OP_PND_CLR = 2'd3
  } irqx_op_e;
endpackage

// File: rtl/irqx_prio.sv
module irqx_prio #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downwards so the last hit is the smallest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqx_pend_bank.sv
module irqx_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = lines & ~prev_q;
    // a fresh edge outranks any clear in the same cycle
    pend_d = (pend_q & ~clr_mask) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqx_group.sv
module irqx_group #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  lines,
  input  logic [W-1:0]  en_set,
  input  logic [W-1:0]  en_clr,
  input  logic [W-1:0]  pnd_clr,
  input  logic          fetch_hit,
  output logic [W-1:0]  pend_o,
  output logic [W-1:0]  en_o,
  output logic          win_any,
  output logic [IW-1:0] win_idx
);
  logic [W-1:0] en_q, en_d, fetch_clr, clr_all, live;
  logic         en_we;

  always_comb begin
    en_we     = (|en_set) | (|en_clr);
    en_d      = (en_q & ~en_clr) | en_set;
    fetch_clr = (fetch_hit && win_any) ? (W'(1) << win_idx) : '0;
    clr_all   = pnd_clr | fetch_clr;
    live      = pend_o & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  irqx_pend_bank #(.W(W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (lines),
    .clr_mask (clr_all),
    .pend_o   (pend_o)
  );

  irqx_prio #(.W(W), .IW(IW)) u_prio (
    .req (live),
    .any (win_any),
    .idx (win_idx)
  );

  assign en_o = en_q;
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander #(
  parameter int NUM_GROUPS = 12,
  parameter int LINES      = 8
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [NUM_GROUPS*LINES-1:0]                      irq_lines,
  input  logic                                             wr_en,
  input  logic [1:0]                                       wr_op,
  input  logic [$clog2(NUM_GROUPS)-1:0]                    wr_group,
  input  logic [((NUM_GROUPS > LINES) ? NUM_GROUPS : LINES)-1:0] wr_data,
  input  logic                                             fetch_strobe,
  input  logic [$clog2(NUM_GROUPS)-1:0]                    fetch_group,
  output logic [NUM_GROUPS-1:0]                            grp_req,
  output logic                                             vec_valid,
  output logic [$clog2(NUM_GROUPS)+$clog2(LINES)-1:0]      vec_idx
);
  import irqx_pkg::*;

  localparam int GW = $clog2(NUM_GROUPS);
  localparam int LW = $clog2(LINES);
  localparam int VW = GW + LW;
  localparam int NT = NUM_GROUPS * LINES;

  irqx_op_e              op;
  logic                  fetch_ok;
  logic [NUM_GROUPS-1:0] ack_q, ack_d, ack_clr, ack_set, win_any;
  logic                  ack_we;
  logic [LW-1:0]         win_idx [NUM_GROUPS];
  logic [NT-1:0]         pend_all, en_all;
  logic                  sel_any;
  logic [LW-1:0]         sel_idx;
  logic [VW-1:0]         vec_d, vec_q;
  logic                  vv_q;

  assign op       = irqx_op_e'(wr_op);
  assign fetch_ok = fetch_strobe && (fetch_group < GW'(NUM_GROUPS));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic             wr_hit, f_hit;
    logic [LINES-1:0] es, ec, pc;

    always_comb begin
      wr_hit     = wr_en && (wr_group == GW'(g));
      f_hit      = fetch_strobe && (fetch_group == GW'(g));
      es         = (wr_hit && op == OP_EN_SET)  ? wr_data[LINES-1:0] : '0;
      ec         = (wr_hit && op == OP_EN_CLR)  ? wr_data[LINES-1:0] : '0;
      pc         = (wr_hit && op == OP_PND_CLR) ? wr_data[LINES-1:0] : '0;
      ack_set[g] = f_hit;
      ack_clr[g] = wr_en && (op == OP_ACK_CLR) && wr_data[g];
    end

    irqx_group #(.W(LINES), .IW(LW)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines     (irq_lines[g*LINES +: LINES]),
      .en_set    (es),
      .en_clr    (ec),
      .pnd_clr   (pc),
      .fetch_hit (f_hit),
      .pend_o    (pend_all[g*LINES +: LINES]),
      .en_o      (en_all[g*LINES +: LINES]),
      .win_any   (win_any[g]),
      .win_idx   (win_idx[g])
    );
  end

  // acknowledge latch: fetch set beats a same-cycle software clear
  always_comb begin
    ack_we = (|ack_set) | (|ack_clr);
    ack_d  = (ack_q & ~ack_clr) | ack_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= '0;
    else if (ack_we) ack_q <= ack_d;
  end

  assign grp_req = win_any & ~ack_q;

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (fetch_group == GW'(g)) begin
        sel_any = win_any[g];
        sel_idx = win_idx[g];
      end
    end
    vec_d = {fetch_group, (sel_any ? sel_idx : LW'(0))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      vv_q <= fetch_ok;
      if (fetch_ok) vec_q <= vec_d;
    end
  end

  assign vec_valid = vv_q;
  assign vec_idx   = vec_q;
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int NUM_GROUPS = 12,
  parameter int LINES      = 8
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic [NUM_GROUPS-1:0]                       grp_req,
  input logic [NUM_GROUPS-1:0]                       ack,
  input logic [NUM_GROUPS*LINES-1:0]                 pend,
  input logic [NUM_GROUPS*LINES-1:0]                 en,
  input logic                                        wr_en,
  input logic [1:0]                                  wr_op,
  input logic [((NUM_GROUPS > LINES) ? NUM_GROUPS : LINES)-1:0] wr_data,
  input logic                                        fetch_strobe,
  input logic [$clog2(NUM_GROUPS)-1:0]               fetch_group,
  input logic                                        vec_valid,
  input logic [$clog2(NUM_GROUPS)+$clog2(LINES)-1:0] vec_idx
);
  localparam int GW = $clog2(NUM_GROUPS);
  localparam int LW = $clog2(LINES);
  localparam int VW = GW + LW;

  logic fok;
  assign fok = fetch_strobe && (fetch_group < GW'(NUM_GROUPS));

  assert_ack_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_req & ack) == '0);

  assert_fetch_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fok |=> ack[$past(fetch_group)]);

  assert_vec_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fok |=> vec_valid);

  assert_no_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fok |=> !vec_valid);

  assert_vec_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fok |=> (vec_idx[VW-1:LW] == $past(fetch_group)));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'd2 && !fetch_strobe) |=>
      ((ack & $past(wr_data[NUM_GROUPS-1:0])) == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_req_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_req[g] |-> |(pend[g*LINES +: LINES] & en[g*LINES +: LINES]));
  end
endmodule

bind irqx_expander irqx_checker #(.NUM_GROUPS(NUM_GROUPS), .LINES(LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .grp_req      (grp_req),
  .ack          (ack_q),
  .pend         (pend_all),
  .en           (en_all),
  .wr_en        (wr_en),
  .wr_op        (wr_op),
  .wr_data      (wr_data),
  .fetch_strobe (fetch_strobe),
  .fetch_group  (fetch_group),
  .vec_valid    (vec_valid),
  .vec_idx      (vec_idx)
);

// File: tb/sim_irqx_expander.sv
module sim_irqx_expander;
  localparam int NG = 12;
  localparam int NL = 8;
  localparam int NT = NG * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] irq;
  logic          wr_en;
  logic [1:0]    wr_op;
  logic [3:0]    wr_group;
  logic [11:0]   wr_data;
  logic          fetch_strobe;
  logic [3:0]    fetch_group;
  logic [NG-1:0] grp_req;
  logic          vec_valid;
  logic [6:0]    vec_idx;

  int checks = 0;
  int errors = 0;
  bit live = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqx_expander u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq),
    .wr_en(wr_en), .wr_op(wr_op), .wr_group(wr_group), .wr_data(wr_data),
    .fetch_strobe(fetch_strobe), .fetch_group(fetch_group),
    .grp_req(grp_req), .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  // behavioural reference model
  logic [NT-1:0] m_prev, m_pend;
  logic [NL-1:0] m_en [NG];
  logic [NG-1:0] m_ack;
  logic          m_vv;
  int            m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_pend = '0; m_ack = '0; m_vv = 0; m_vec = 0;
      for (int g = 0; g < NG; g++) m_en[g] = '0;
    end else begin
      logic [NT-1:0] n_pend;
      logic [NG-1:0] n_ack;
      logic [NL-1:0] n_en [NG];
      int fg, win;
      n_pend = m_pend;
      n_ack  = m_ack;
      for (int g = 0; g < NG; g++) n_en[g] = m_en[g];
      fg = int'(fetch_group);
      if (fetch_strobe && fg < NG) begin
        win = -1;
        for (int i = NL - 1; i >= 0; i--)
          if (m_pend[fg*NL+i] && m_en[fg][i]) win = i;
        if (win >= 0) begin
          m_vec = fg * NL + win;
          n_pend[fg*NL+win] = 1'b0;
        end else begin
          m_vec = fg * NL;
        end
        m_vv = 1;
      end else begin
        m_vv = 0;
      end
      if (wr_en) begin
        int wg;
        wg = int'(wr_group);
        case (wr_op)
          2'd0: if (wg < NG) n_en[wg] = n_en[wg] | wr_data[NL-1:0];
          2'd1: if (wg < NG) n_en[wg] = n_en[wg] & ~wr_data[NL-1:0];
          2'd2: n_ack = n_ack & ~wr_data[NG-1:0];
          default: if (wg < NG)
            for (int i = 0; i < NL; i++) if (wr_data[i]) n_pend[wg*NL+i] = 1'b0;
        endcase
      end
      if (fetch_strobe && fg < NG) n_ack[fg] = 1'b1;
      n_pend = n_pend | (irq & ~m_prev);
      m_prev = irq;
      m_pend = n_pend;
      m_ack  = n_ack;
      for (int g = 0; g < NG; g++) m_en[g] = n_en[g];
    end
  end

  function automatic logic [NG-1:0] model_req();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = (|(m_pend[g*NL +: NL] & m_en[g])) & ~m_ack[g];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NG-1:0] er;
    er = model_req();
    chk(grp_req == er, "R3 grp_req", int'(grp_req), int'(er));
    chk(vec_valid == m_vv, "R7 vec_valid", int'(vec_valid), int'(m_vv));
    if (m_vv) chk(int'(vec_idx) == m_vec, "R7 vec_idx", int'(vec_idx), m_vec);
  endtask

  task automatic cyc();
    @(negedge clk);
    if (live) compare_all();
  endtask

  task automatic do_wr(input logic [1:0] op, input int g, input logic [11:0] d);
    wr_en = 1; wr_op = op; wr_group = 4'(g); wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic do_fetch(input int g);
    fetch_strobe = 1; fetch_group = 4'(g);
    cyc();
    fetch_strobe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq = '0; wr_en = 0; wr_op = 0; wr_group = 0; wr_data = 0;
    fetch_strobe = 0; fetch_group = 0;
    repeat (3) @(negedge clk);
    chk(grp_req == '0, "R1 reset grp_req", int'(grp_req), 0);
    chk(vec_valid == 1'b0, "R1 reset vec_valid", int'(vec_valid), 0);
    rst_n = 1;
    live = 1;
    cyc();
    chk(grp_req == '0, "R1 after release", int'(grp_req), 0);

    // R4 enable set, R2 edge sets pending, R3 request
    do_wr(2'd0, 0, 12'h0FF);
    irq[3] = 1; cyc();
    chk(grp_req[0] == 1'b1, "R2 edge pending", int'(grp_req[0]), 1);

    // R7 vector, R5 ack blocks
    do_fetch(0);
    chk(vec_valid && vec_idx == 7'd3, "R7 group0 line3", int'(vec_idx), 3);
    chk(grp_req[0] == 1'b0, "R5 ack blocks", int'(grp_req[0]), 0);

    // R8 pending retired, R2 held level does not retrigger
    do_wr(2'd2, 0, 12'hFFF);
    cyc();
    chk(grp_req[0] == 1'b0, "R8 R2 no retrigger", int'(grp_req[0]), 0);
    irq[3] = 0;

    // enabled line wins over lower-numbered disabled one
    do_wr(2'd0, 4, 12'h020);
    irq[34] = 1; irq[37] = 1; cyc();
    irq[34] = 0; irq[37] = 0; cyc();
    chk(grp_req[4] == 1'b1, "R3 group4 req", int'(grp_req[4]), 1);
    do_fetch(4);
    chk(vec_idx == 7'd37, "R7 enabled line only", int'(vec_idx), 37);
    do_wr(2'd2, 0, 12'h010);
    chk(grp_req[4] == 1'b0, "R3 disabled pending", int'(grp_req[4]), 0);
    do_wr(2'd0, 4, 12'h004);
    chk(grp_req[4] == 1'b1, "R4 enable set", int'(grp_req[4]), 1);
    do_wr(2'd1, 4, 12'h004);
    chk(grp_req[4] == 1'b0, "R4 enable clear", int'(grp_req[4]), 0);

    // R9 spurious vector, pending untouched
    do_fetch(4);
    chk(vec_valid && vec_idx == 7'd32, "R9 spurious", int'(vec_idx), 32);
    do_wr(2'd2, 0, 12'h010);
    do_wr(2'd0, 4, 12'h004);
    chk(grp_req[4] == 1'b1, "R9 pending kept", int'(grp_req[4]), 1);

    // R10 pending clear
    do_wr(2'd3, 4, 12'h004);
    chk(grp_req[4] == 1'b0, "R10 pending clear", int'(grp_req[4]), 0);

    // R11 edge wins over clear
    do_wr(2'd0, 7, 12'h001);
    irq[56] = 1;
    do_wr(2'd3, 7, 12'h001);
    chk(grp_req[7] == 1'b1, "R11 edge beats clear", int'(grp_req[7]), 1);
    irq[56] = 0;
    do_fetch(7);
    chk(vec_idx == 7'd56, "R7 group7", int'(vec_idx), 56);

    // R6 masked release, priority in last group
    do_wr(2'd0, 11, 12'h0FF);
    irq[95] = 1; irq[90] = 1; cyc();
    irq[95] = 0; irq[90] = 0;
    do_fetch(11);
    chk(vec_idx == 7'd90, "R7 lowest line wins", int'(vec_idx), 90);
    chk(grp_req[11] == 1'b0, "R5 group11 held", int'(grp_req[11]), 0);
    do_wr(2'd2, 0, 12'h080);
    chk(grp_req[11] == 1'b0, "R6 unmasked group stays", int'(grp_req[11]), 0);
    do_wr(2'd2, 0, 12'hFFF);
    chk(grp_req[11] == 1'b1, "R6 all ones release", int'(grp_req[11]), 1);
    do_fetch(11);
    chk(vec_idx == 7'd95, "R7 last line", int'(vec_idx), 95);

    // R6 same-cycle fetch keeps its own latch
    irq[8] = 1; do_wr(2'd0, 1, 12'h001);
    irq[8] = 0; cyc();
    wr_en = 1; wr_op = 2'd2; wr_data = 12'hFFF; fetch_strobe = 1; fetch_group = 4'd1;
    cyc();
    wr_en = 0; fetch_strobe = 0;
    chk(vec_idx == 7'd8, "R6 fetch with clear", int'(vec_idx), 8);

    // R7 out-of-range group
    do_fetch(12);
    chk(vec_valid == 1'b0, "R7 group out of range", int'(vec_valid), 0);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NT; b++)
        if (($urandom % 64) == 0) irq[b] = ~irq[b];
      wr_en = (($urandom % 4) == 0);
      wr_op = 2'($urandom);
      wr_group = 4'($urandom % 13);
      wr_data = (($urandom % 4) == 0) ? 12'hFFF : 12'($urandom);
      fetch_strobe = (($urandom % 3) == 0);
      fetch_group = 4'($urandom % 13);
      cyc();
    end
    wr_en = 0; fetch_strobe = 0;
    cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule